// File: doc/BRIEF.md
# Jet and Electron/Tau Overlap Tagger

This block takes a trigger grid of region-of-interest bins, 32 rows in phi by 32 columns in eta, and streams it in one phi row per accepted clock. Each bin holds a 16-bit electron/tau threshold word and an 8-bit jet threshold word. For every jet threshold a software-set 8-bit mask chooses which electron/tau thresholds take part. A jet bin gets its overlap bit for a threshold when an enabled electron/tau hit lies in the 3 by 3 bin neighbourhood around it. Phi wraps around. Eta ends at the grid edge.

The block puts out one tagged row per clock cycle with its phi index. All 8 threshold overlap bits of a bin are packed side by side. For each jet threshold the block keeps two running counts, both saturating: an inclusive count of all jet bins and an exclusive count of jet bins left untagged. Row 0 and row 1 are kept until the end of the event. After the last row arrives, the two wrap-around rows are finished in two more cycles, and a done pulse marks the final counts.

Top module: `ovl_tagger`

## Requirements
- R1: Bin e of a row occupies `row_em[e*16 +: 16]` and `row_jet[e*8 +: 8]`. Electron/tau bit t (t = 0..7) counts as a hit for jet threshold j only when `en_mask[j*8 + t]` is 1. Bits 8..15 never cause a tag.
- R2: `ov_map[e*8 + j]` is 1 exactly when jet bit j of bin e is set and some selected hit for threshold j lies in rows phi-1..phi+1 and columns e-1..e+1.
- R3: Along phi the window wraps, so rows 31 and 0 are neighbours.
- R4: Along eta there is no wrap. Columns below 0 or above 31 hold no hits, so columns 0 and 31 are not neighbours.
- R5: An overlap bit is never set on a bin whose jet bit for that threshold is clear.
- R6: `incl_cnt[j*3 +: 3]` counts the event's jet bins with bit j set. It saturates at 7 and never wraps.
- R7: `excl_cnt[j*3 +: 3]` counts the jet bins with bit j set and overlap bit j clear. It saturates at 7 and is never above the inclusive count.
- R8: A row accepted with `row_sof` is phi 0. The next 31 accepted rows are phi 1..31, and gaps between them are allowed. Row k (k ≥ 2) gives `ov_valid` with `ov_phi` = k-1 in the following cycle. Phi 31 follows one cycle after the result for row 30, and phi 0 one cycle after that. The phi 0 result comes with a one-cycle `done`.
- R9: A row with `row_sof` clears both counts, so each event counts from zero.
- R10: After reset, `ov_valid`, `done` and both counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| row_valid | input | 1 | A row is present this cycle |
| row_sof | input | 1 | Present row is phi 0 of a new event |
| row_em | input | 512 | Electron/tau words, 16 bits per eta bin |
| row_jet | input | 256 | Jet threshold bits, 8 per eta bin |
| en_mask | input | 64 | Per jet threshold, 8 enable bits over electron/tau bits 0..7 |
| ov_valid | output | 1 | A tagged row is on ov_map |
| ov_phi | output | 5 | Phi index of the tagged row |
| ov_map | output | 256 | Overlap bits, 8 per eta bin |
| incl_cnt | output | 24 | Saturating inclusive counts, 3 bits per jet threshold |
| excl_cnt | output | 24 | Saturating exclusive counts, 3 bits per jet threshold |
| done | output | 1 | Event finished; counts are final |

## Verification
The assertions assume that no row arrives in the two cycles that finish the wrap-around rows. They also assume that every event begins with a start-of-event row, followed by exactly 31 further rows. The mask is assumed to stay fixed for the whole event. The bench keeps to these assumptions: it sends 32 rows per event with random idle gaps, holds the mask for the event, and waits for the done pulse before it starts the next event.

// File: rtl/ovl_pkg.sv
package ovl_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_LOAD  = 2'd1,
        PH_WRAPA = 2'd2,
        PH_WRAPB = 2'd3
    } phase_e;

    function automatic int sat_add(input int acc, input int inc, input int lim);
        int s;
        s = acc + inc;
        return (s > lim) ? lim : s;
    endfunction

endpackage

// File: rtl/ovl_hitsel.sv
module ovl_hitsel #(
    parameter int ETA_N = 32,
    parameter int EMT_W = 16,
    parameter int SEL_W = 8,
    parameter int JET_N = 8
) (
    input  logic [ETA_N*EMT_W-1:0] row_em,
    input  logic [JET_N*SEL_W-1:0] en_mask,
    output logic [ETA_N*JET_N-1:0] hit
);
    logic unused_hi;
    assign unused_hi = ^row_em;

    for (genvar e = 0; e < ETA_N; e++) begin : g_eta
        for (genvar j = 0; j < JET_N; j++) begin : g_thr
            assign hit[e*JET_N+j] =
                |(row_em[e*EMT_W +: SEL_W] & en_mask[j*SEL_W +: SEL_W]);
        end
    end
endmodule

// File: rtl/ovl_window.sv
module ovl_window #(
    parameter int ETA_N = 32,
    parameter int JET_N = 8
) (
    input  logic [ETA_N*JET_N-1:0] hit_up,
    input  logic [ETA_N*JET_N-1:0] hit_mid,
    input  logic [ETA_N*JET_N-1:0] hit_dn,
    input  logic [ETA_N*JET_N-1:0] jet_mid,
    output logic [ETA_N*JET_N-1:0] ov
);
    logic [ETA_N*JET_N-1:0] col_or;
    logic [ETA_N*JET_N-1:0] from_hi;
    logic [ETA_N*JET_N-1:0] from_lo;

    always_comb begin
        col_or  = hit_up | hit_mid | hit_dn;
        // neighbour columns: zeros shift in at both eta edges
        from_hi = col_or >> JET_N;
        from_lo = col_or << JET_N;
        ov      = jet_mid & (col_or | from_hi | from_lo);
    end
endmodule

// File: rtl/ovl_count.sv
module ovl_count #(
    parameter int ETA_N = 32,
    parameter int JET_N = 8,
    parameter int CNT_W = 3
) (
    input  logic [ETA_N*JET_N-1:0] jet_row,
    input  logic [ETA_N*JET_N-1:0] ov_row,
    input  logic [JET_N*CNT_W-1:0] incl_in,
    input  logic [JET_N*CNT_W-1:0] excl_in,
    output logic [JET_N*CNT_W-1:0] incl_out,
    output logic [JET_N*CNT_W-1:0] excl_out
);
    localparam int LIM = (1 << CNT_W) - 1;

    for (genvar j = 0; j < JET_N; j++) begin : g_thr
        always_comb begin
            int n_all;
            int n_free;
            n_all  = 0;
            n_free = 0;
            for (int e = 0; e < ETA_N; e++) begin
                n_all  = n_all  + int'(jet_row[e*JET_N+j]);
                n_free = n_free + int'(jet_row[e*JET_N+j] & ~ov_row[e*JET_N+j]);
            end
            incl_out[j*CNT_W +: CNT_W] = CNT_W'(ovl_pkg::sat_add(
                int'(incl_in[j*CNT_W +: CNT_W]), n_all, LIM));
            excl_out[j*CNT_W +: CNT_W] = CNT_W'(ovl_pkg::sat_add(
                int'(excl_in[j*CNT_W +: CNT_W]), n_free, LIM));
        end
    end
endmodule

// File: rtl/ovl_tagger.sv
module ovl_tagger #(
    parameter int PHI_N = 32,
    parameter int ETA_N = 32,
    parameter int EMT_W = 16,
    parameter int SEL_W = 8,
    parameter int JET_N = 8,
    parameter int CNT_W = 3,
    localparam int PHI_W = $clog2(PHI_N),
    localparam int ROW_W = ETA_N*JET_N,
    localparam int CSET_W = JET_N*CNT_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   row_valid,
    input  logic                   row_sof,
    input  logic [ETA_N*EMT_W-1:0] row_em,
    input  logic [ETA_N*JET_N-1:0] row_jet,
    input  logic [JET_N*SEL_W-1:0] en_mask,
    output logic                   ov_valid,
    output logic [PHI_W-1:0]       ov_phi,
    output logic [ROW_W-1:0]       ov_map,
    output logic [CSET_W-1:0]      incl_cnt,
    output logic [CSET_W-1:0]      excl_cnt,
    output logic                   done
);
    import ovl_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [PHI_W-1:0]  rcnt;
        logic [ROW_W-1:0]  r0_h, r0_j, r1_h, r1_j;
        logic [ROW_W-1:0]  p2_h, p2_j, p1_h, p1_j;
        logic              ov_valid;
        logic [PHI_W-1:0]  ov_phi;
        logic [ROW_W-1:0]  ov_map;
        logic [CSET_W-1:0] incl;
        logic [CSET_W-1:0] excl;
        logic              done;
    } state_t;

    state_t s_d, s_q;

    logic [ROW_W-1:0]  in_h;
    logic [ROW_W-1:0]  w_up, w_mid, w_dn, w_jet, w_ov;
    logic [CSET_W-1:0] c_incl, c_excl;

    ovl_hitsel #(.ETA_N(ETA_N), .EMT_W(EMT_W), .SEL_W(SEL_W), .JET_N(JET_N)) u_hitsel (
        .row_em (row_em),
        .en_mask(en_mask),
        .hit    (in_h)
    );

    ovl_window #(.ETA_N(ETA_N), .JET_N(JET_N)) u_window (
        .hit_up (w_up),
        .hit_mid(w_mid),
        .hit_dn (w_dn),
        .jet_mid(w_jet),
        .ov     (w_ov)
    );

    ovl_count #(.ETA_N(ETA_N), .JET_N(JET_N), .CNT_W(CNT_W)) u_count (
        .jet_row (w_jet),
        .ov_row  (w_ov),
        .incl_in (s_q.incl),
        .excl_in (s_q.excl),
        .incl_out(c_incl),
        .excl_out(c_excl)
    );

    always_comb begin
        logic             proc;
        logic [PHI_W-1:0] proc_phi;
        s_d          = s_q;
        s_d.ov_valid = 1'b0;
        s_d.done     = 1'b0;
        proc         = 1'b0;
        proc_phi     = '0;
        w_up         = s_q.p2_h;
        w_mid        = s_q.p1_h;
        w_dn         = in_h;
        w_jet        = s_q.p1_j;

        case (s_q.phase)
            PH_IDLE, PH_LOAD: begin
                if (row_valid && row_sof) begin
                    s_d.phase = PH_LOAD;
                    s_d.rcnt  = PHI_W'(1);
                    s_d.r0_h  = in_h;
                    s_d.r0_j  = row_jet;
                    s_d.p1_h  = in_h;
                    s_d.p1_j  = row_jet;
                    s_d.incl  = '0;
                    s_d.excl  = '0;
                end else if (row_valid && s_q.phase == PH_LOAD) begin
                    if (s_q.rcnt == PHI_W'(1)) begin
                        s_d.r1_h = in_h;
                        s_d.r1_j = row_jet;
                    end else begin
                        proc     = 1'b1;
                        proc_phi = s_q.rcnt - PHI_W'(1);
                    end
                    s_d.p2_h = s_q.p1_h;
                    s_d.p2_j = s_q.p1_j;
                    s_d.p1_h = in_h;
                    s_d.p1_j = row_jet;
                    s_d.rcnt = s_q.rcnt + PHI_W'(1);
                    if (s_q.rcnt == PHI_W'(PHI_N-1)) s_d.phase = PH_WRAPA;
                end
            end
            PH_WRAPA: begin
                w_dn      = s_q.r0_h;
                proc      = 1'b1;
                proc_phi  = PHI_W'(PHI_N-1);
                s_d.phase = PH_WRAPB;
            end
            default: begin
                w_up      = s_q.p1_h;
                w_mid     = s_q.r0_h;
                w_dn      = s_q.r1_h;
                w_jet     = s_q.r0_j;
                proc      = 1'b1;
                proc_phi  = '0;
                s_d.done  = 1'b1;
                s_d.phase = PH_IDLE;
            end
        endcase

        if (proc) begin
            s_d.ov_valid = 1'b1;
            s_d.ov_phi   = proc_phi;
            s_d.ov_map   = w_ov;
            s_d.incl     = c_incl;
            s_d.excl     = c_excl;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign ov_valid = s_q.ov_valid;
    assign ov_phi   = s_q.ov_phi;
    assign ov_map   = s_q.ov_map;
    assign incl_cnt = s_q.incl;
    assign excl_cnt = s_q.excl;
    assign done     = s_q.done;

    // R8: done only comes with the final, phi 0 row
    a_r8_done_with_row0: assert property (@(posedge clk) disable iff (rst)
        done |-> (ov_valid && ov_phi == '0));

    // R8: the start-of-event row itself yields no result
    a_r8_sof_no_output: assert property (@(posedge clk) disable iff (rst)
        (row_valid && row_sof) |=> !ov_valid);

    // R8 input assumption: no rows while finishing the wrapped rows
    a_r8_quiet_in_wrap: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == PH_WRAPA || s_q.phase == PH_WRAPB) |-> !row_valid);

    for (genvar j = 0; j < JET_N; j++) begin : g_chk
        // R6: counts only grow within an event
        a_r6_incl_monotonic: assert property (@(posedge clk) disable iff (rst)
            !(row_valid && row_sof) |=>
                incl_cnt[j*CNT_W +: CNT_W] >= $past(incl_cnt[j*CNT_W +: CNT_W]));
        // R7: exclusive never exceeds inclusive
        a_r7_excl_le_incl: assert property (@(posedge clk) disable iff (rst)
            excl_cnt[j*CNT_W +: CNT_W] <= incl_cnt[j*CNT_W +: CNT_W]);
        // R9: start of event empties the counts
        a_r9_sof_clears: assert property (@(posedge clk) disable iff (rst)
            (row_valid && row_sof) |=>
                (incl_cnt[j*CNT_W +: CNT_W] == '0 && excl_cnt[j*CNT_W +: CNT_W] == '0));
    end
endmodule

// File: tb/ovl_tagger_bench.sv
module ovl_tagger_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         row_valid = 1'b0;
    logic         row_sof = 1'b0;
    logic [511:0] row_em = '0;
    logic [255:0] row_jet = '0;
    logic [63:0]  en_mask = '0;
    logic         ov_valid;
    logic [4:0]   ov_phi;
    logic [255:0] ov_map;
    logic [23:0]  incl_cnt;
    logic [23:0]  excl_cnt;
    logic         done;

    int tests = 0;
    int fails = 0;
    int nout = 0;
    int done_seen = 0;
    int cycles = 0;

    logic [15:0] em [32][32];
    logic [7:0]  jt [32][32];

    always #2 clk = ~clk;

    ovl_tagger u_ovl_tagger (
        .clk(clk), .rst(rst), .row_valid(row_valid), .row_sof(row_sof),
        .row_em(row_em), .row_jet(row_jet), .en_mask(en_mask),
        .ov_valid(ov_valid), .ov_phi(ov_phi), .ov_map(ov_map),
        .incl_cnt(incl_cnt), .excl_cnt(excl_cnt), .done(done)
    );

    function automatic logic [255:0] exp_ov(input int p);
        logic [255:0] r;
        r = '0;
        for (int e = 0; e < 32; e++)
            for (int j = 0; j < 8; j++)
                if (jt[p][e][j])
                    for (int dp = -1; dp <= 1; dp++)
                        for (int de = -1; de <= 1; de++)
                            if (e + de >= 0 && e + de < 32)
                                if ((em[(p + dp + 32) % 32][e + de][7:0] & en_mask[j*8 +: 8]) != 0)
                                    r[e*8+j] = 1'b1;
        return r;
    endfunction

    function automatic logic [23:0] exp_cnt(input bit excl);
        logic [23:0] r;
        logic [255:0] ov;
        int n [8];
        for (int j = 0; j < 8; j++) n[j] = 0;
        for (int p = 0; p < 32; p++) begin
            ov = exp_ov(p);
            for (int e = 0; e < 32; e++)
                for (int j = 0; j < 8; j++)
                    if (jt[p][e][j] && !(excl && ov[e*8+j])) n[j]++;
        end
        for (int j = 0; j < 8; j++) r[j*3 +: 3] = 3'(n[j] > 7 ? 7 : n[j]);
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [255:0] act,
                         input logic [255:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // output monitor
    always @(negedge clk) begin
        if (!rst) begin
            cycles++;
            if (ov_valid) begin
                int ep;
                logic [255:0] em_exp;
                ep = (nout < 31) ? nout + 1 : 0;
                em_exp = exp_ov(ep);
                check(ov_phi == 5'(ep), "R8 phi order", 256'(ov_phi), 256'(ep));
                check(ov_map == em_exp, "R2/R3/R4/R5/R1 overlap row", ov_map, em_exp);
                nout++;
                if (done) begin
                    check(nout == 32, "R8 done after 32 rows", 256'(nout), 256'd32);
                    check(incl_cnt == exp_cnt(1'b0), "R6 inclusive counts",
                          256'(incl_cnt), 256'(exp_cnt(1'b0)));
                    check(excl_cnt == exp_cnt(1'b1), "R7 exclusive counts",
                          256'(excl_cnt), 256'(exp_cnt(1'b1)));
                    done_seen = 1;
                end
            end else if (done) begin
                check(1'b0, "R8 done without row", 256'd1, 256'd0);
            end
        end
    end

    task automatic clear_grid();
        for (int p = 0; p < 32; p++)
            for (int e = 0; e < 32; e++) begin
                em[p][e] = '0;
                jt[p][e] = '0;
            end
    endtask

    task automatic run_event();
        nout = 0;
        done_seen = 0;
        @(negedge clk);
        for (int k = 0; k < 32; k++) begin
            row_valid = 1'b1;
            row_sof   = (k == 0);
            for (int e = 0; e < 32; e++) begin
                row_em[e*16 +: 16] = em[k][e];
                row_jet[e*8 +: 8]  = jt[k][e];
            end
            @(negedge clk);
            if (k == 0) begin
                check(incl_cnt == '0 && excl_cnt == '0, "R9 counts cleared at start",
                      256'({incl_cnt, excl_cnt}), 256'd0);
            end
            check(ov_valid == (k >= 2), "R8 row result timing", 256'(ov_valid), 256'(k >= 2));
            if ($urandom % 3 == 0 || k == 31) begin
                row_valid = 1'b0;
                row_sof   = 1'b0;
                repeat ($urandom % 3) @(negedge clk);
            end
        end
        row_valid = 1'b0;
        row_sof   = 1'b0;
        for (int w = 0; w < 10 && !done_seen; w++) @(negedge clk);
        check(done_seen == 1, "R8 done pulse", 256'(done_seen), 256'd1);
    endtask

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        clear_grid();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state
        check(!ov_valid && !done && incl_cnt == '0 && excl_cnt == '0, "R10 reset state",
              256'({ov_valid, done, incl_cnt, excl_cnt}), 256'd0);

        // R3: phi wrap between rows 31 and 0
        clear_grid();
        en_mask = '1;
        jt[31][5] = 8'hFF;  em[0][6]  = 16'h0001;
        jt[0][10] = 8'h0F;  em[31][9] = 16'h0010;
        run_event();

        // R4: no eta wrap, but inner neighbour tags
        clear_grid();
        jt[7][0]  = 8'hFF;  em[7][31] = 16'h00FF;
        jt[9][31] = 8'hFF;  em[9][0]  = 16'h00FF;
        jt[12][0] = 8'h33;  em[13][1] = 16'h0004;
        run_event();

        // R1: upper electron/tau bits never tag
        clear_grid();
        for (int p = 0; p < 32; p++)
            for (int e = 0; e < 32; e++) begin
                em[p][e] = {8'($urandom), 8'h00};
                if ($urandom % 16 == 0) jt[p][e] = 8'($urandom);
            end
        run_event();

        // R1: mask selects threshold j only from electron/tau bit j
        clear_grid();
        for (int j = 0; j < 8; j++) en_mask[j*8 +: 8] = 8'(1 << j);
        for (int t = 0; t < 8; t++) begin
            jt[3*t+1][4*t+2] = 8'hFF;
            em[3*t+2][4*t+3] = 16'(1 << t);
        end
        run_event();

        // R6/R7: dense grid saturates the counts
        clear_grid();
        en_mask = 64'h0F0F_F0F0_00FF_1234;
        for (int p = 0; p < 32; p++)
            for (int e = 0; e < 32; e++) begin
                jt[p][e] = 8'($urandom);
                if ($urandom % 8 == 0) em[p][e] = 16'($urandom);
            end
        run_event();

        // random sparse events, mostly below saturation
        for (int ev = 0; ev < 6; ev++) begin
            clear_grid();
            en_mask = {$urandom, $urandom};
            for (int p = 0; p < 32; p++)
                for (int e = 0; e < 32; e++) begin
                    for (int j = 0; j < 8; j++)
                        if ($urandom % 200 == 0) jt[p][e][j] = 1'b1;
                    if ($urandom % 20 == 0) em[p][e] = 16'($urandom);
                end
            run_event();
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule